// File: doc/BRIEF.md
# Dual-Channel Timer Input Capture

This block records when events happen on two external signals. It compares each signal against a free-running 8-bit count that arrives from outside. When a channel sees the edge it has been told to watch for, it copies the current count into that channel's capture register and raises that channel's pending flag. Software chooses the edge for each channel. It reads the captured counts and the flags over a small register bus, then acknowledges each event with a two-step handshake.

Both pending flags drive one shared interrupt request. A single enable bit and an active-low mask input gate that request. When the timer runs in a one-pulse or PWM mode, channel 1 is taken out of service and channel 2 keeps working. The pins go through a synchronizer before edge detection, so the block can sit next to pins that are asynchronous to the timer clock.

Top module: `tcap_dual`

## Requirements
- R1: A pin transition that is first sampled at rising clock edge E0 is captured at edge E2. The capture register then holds the value `cnt_val` had at E2, which gives a resolution of one count.
- R2: Control register (address 0) bit 0 selects the edge for channel 1 and bit 1 selects the edge for channel 2. A value of 1 selects rising and 0 selects falling. A transition in the other direction changes neither the flag nor the capture register.
- R3: The capture registers (address 2 for channel 1, address 3 for channel 2) cannot be written from the bus. A bus write to either one leaves its contents unchanged.
- R4: A capture sets that channel's flag in the status register (address 1, bit 0 for channel 1 and bit 1 for channel 2). The capture register always holds the count from the most recent capture.
- R5: A flag clears after two steps in order. First, the status register is read while the flag is set. Second, that channel's capture register is accessed, by either a read or a write. The other channel's flag is not affected.
- R6: Accessing a capture register without a preceding status read that saw the flag set does not clear the flag.
- R7: A capture that lands between the status read and the capture-register access cancels the pending clear. The flag stays set, and the register holds the newer count.
- R8: `irq` is high exactly when at least one flag is set, control bit 2 (interrupt enable) is 1, and `int_mask_n` is 1. A flag stays set while the request is gated off, so the request appears once the gating lifts.
- R9: While `pulse_mode` is high, channel 1 neither captures nor sets its flag, and channel 2 keeps working. When `pulse_mode` returns low, channel 1 works again.
- R10: After reset, the control, status and capture registers read as zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | 8 | Free-running counter value |
| cap_pin | input | 2 | Capture inputs; bit 0 is channel 1, bit 1 is channel 2 |
| pulse_mode | input | 1 | High when the timer is in one-pulse or PWM mode |
| int_mask_n | input | 1 | Global interrupt mask, active low (0 means masked) |
| bus_sel | input | 1 | Register access strobe, one access per clock |
| bus_wr | input | 1 | 1 means write, 0 means read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Capture interrupt request |

## Verification
The hardest state to reach from the ports is a clear that has been armed and is then cancelled by a fresh capture before the acknowledging access arrives. To reach it, the stimulus reads status and then drives a second qualifying edge on the same pin. It waits out the synchronizer latency before it issues the capture-register read. Arming is also checked across channels. With both flags set, one status read arms both channels, and the bench then acknowledges the channels one at a time to show that each clear affects only its own flag. Every capture stamp is predicted from a counter that steps once per cycle, so an error of even one cycle in the synchronizer or edge path changes the expected value.

// File: rtl/tcap_pkg.sv
// Package: shared register map and field positions for the dual capture unit.
// Assumes a 2-bit register address and one control bit per channel.
package tcap_pkg;
    localparam int ADDR_W      = 2;
    localparam int N_CH        = 2;
    localparam int CTRL_EN_BIT = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_CAP1 = 2'd2,
        REG_CAP2 = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/tcap_sync_edge.sv
// Module: synchronizes one capture pin and flags a selected transition.
// Assumes the pin is low while reset is held; a pin that is high at reset
// release looks like a rising edge to the detector.
module tcap_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic rise_sel,
    output logic hit
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    logic              synced;

    assign synced = chain_q[STAGES-1];

    // Shift the pin through the synchronizer and remember the last synced level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_i};
            prev_q  <= synced;
        end
    end

    // Report a hit only for the transition direction that rise_sel picks.
    always_comb begin
        if (rise_sel) hit = synced & ~prev_q;
        else          hit = ~synced & prev_q;
    end
endmodule

// File: rtl/tcap_channel.sv
// Module: one capture channel, made of a stamp register, a pending flag and
// the arm bit for the two-step clear. Assumes stat_rd and cap_acc are never
// high in the same cycle, because they decode different addresses.
module tcap_channel #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             blocked,
    input  logic [CNT_W-1:0] cnt,
    input  logic             stat_rd,
    input  logic             cap_acc,
    output logic             flag,
    output logic [CNT_W-1:0] cap
);
    logic take;
    logic arm_q;

    assign take = hit & ~blocked;

    // Latch the counter on an accepted edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    cap <= '0;
        else if (take) cap <= cnt;
    end

    // Arm on a status read that sees the flag; a capture or an access disarms.
    always_ff @(posedge clk) begin
        if (!rst_n)               arm_q <= 1'b0;
        else if (take)            arm_q <= 1'b0;
        else if (stat_rd && flag) arm_q <= 1'b1;
        else if (cap_acc)         arm_q <= 1'b0;
    end

    // Set the flag on a capture; clear it on an armed access. A capture wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                 flag <= 1'b0;
        else if (take)              flag <= 1'b1;
        else if (cap_acc && arm_q)  flag <= 1'b0;
    end
endmodule

// File: rtl/tcap_regs.sv
// Module: bus decode, control register and read-data mux.
// Assumes one access per cycle, with read data valid in the same cycle as the strobe.
module tcap_regs
    import tcap_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_sel,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [CNT_W-1:0]       bus_wdata,
    input  logic [N_CH-1:0]        flags,
    input  logic [N_CH*CNT_W-1:0]  cap_flat,
    output logic [N_CH-1:0]        edge_rise,
    output logic                   irq_en,
    output logic                   stat_rd,
    output logic [N_CH-1:0]        cap_acc,
    output logic [CNT_W-1:0]       rdata
);
    logic ctrl_wr;

    assign ctrl_wr = bus_sel && bus_wr && (bus_addr == REG_CTRL);
    assign stat_rd = bus_sel && !bus_wr && (bus_addr == REG_STAT);

    for (genvar i = 0; i < N_CH; i++) begin : g_acc
        // Any access, read or write, to this channel's capture register.
        assign cap_acc[i] = bus_sel && (bus_addr == ADDR_W'(int'(REG_CAP1) + i));
    end

    // Hold the edge selects and the interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_rise <= '0;
            irq_en    <= 1'b0;
        end else if (ctrl_wr) begin
            edge_rise <= bus_wdata[N_CH-1:0];
            irq_en    <= bus_wdata[CTRL_EN_BIT];
        end
    end

    // Select the register addressed by the bus.
    always_comb begin
        rdata = '0;
        case (bus_addr)
            REG_CTRL: begin
                rdata[N_CH-1:0]    = edge_rise;
                rdata[CTRL_EN_BIT] = irq_en;
            end
            REG_STAT: rdata[N_CH-1:0] = flags;
            REG_CAP1: rdata = cap_flat[0 +: CNT_W];
            REG_CAP2: rdata = cap_flat[CNT_W +: CNT_W];
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/tcap_dual.sv
// Module: top of the dual-channel input capture unit. It ties two
// synchronized edge detectors and two capture channels to the register
// block. Channel 1 is blocked while pulse_mode is high.
module tcap_dual
    import tcap_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic [1:0]        cap_pin,
    input  logic              pulse_mode,
    input  logic              int_mask_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    logic [N_CH-1:0]       hit_vec;
    logic [N_CH-1:0]       flag_vec;
    logic [N_CH-1:0]       edge_rise;
    logic [N_CH-1:0]       cap_acc;
    logic [N_CH-1:0]       block_vec;
    logic [N_CH*CNT_W-1:0] cap_flat;
    logic                  irq_en;
    logic                  stat_rd;

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        if (i == 0) begin : g_blk
            // Channel 1 is out of service in one-pulse and PWM modes.
            assign block_vec[i] = pulse_mode;
        end else begin : g_free
            assign block_vec[i] = 1'b0;
        end

        tcap_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_i    (cap_pin[i]),
            .rise_sel (edge_rise[i]),
            .hit      (hit_vec[i])
        );

        tcap_channel #(.CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (hit_vec[i]),
            .blocked (block_vec[i]),
            .cnt     (cnt_val),
            .stat_rd (stat_rd),
            .cap_acc (cap_acc[i]),
            .flag    (flag_vec[i]),
            .cap     (cap_flat[i*CNT_W +: CNT_W])
        );
    end

    tcap_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flags     (flag_vec),
        .cap_flat  (cap_flat),
        .edge_rise (edge_rise),
        .irq_en    (irq_en),
        .stat_rd   (stat_rd),
        .cap_acc   (cap_acc),
        .rdata     (bus_rdata)
    );

    // One shared request: any pending flag, gated by the enable and the mask.
    assign irq = (|flag_vec) & irq_en & int_mask_n;
endmodule

// File: rtl/tcap_dual_chk.sv
// Checker: temporal properties of tcap_dual, attached with bind below.
// Assumes the register map of tcap_pkg.
module tcap_dual_chk #(
    parameter int CNT_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pulse_mode,
    input logic               int_mask_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [1:0]         bus_addr,
    input logic [1:0]         hit,
    input logic [1:0]         flags,
    input logic [2*CNT_W-1:0] cap_flat,
    input logic               irq
);
    assert_hit_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit[1] |=> flags[1]);

    assert_cap_change_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_flat[CNT_W-1:0]) |-> flags[0]);

    assert_cap_readonly_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd2 && !hit[0]) |=> $stable(cap_flat[CNT_W-1:0]));

    assert_clear_needs_access1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[0]) |-> $past(bus_sel && bus_addr == 2'd2));

    assert_clear_needs_access2_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[1]) |-> $past(bus_sel && bus_addr == 2'd3));

    assert_ch1_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_mode |=> !$rose(flags[0]));

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !int_mask_n |-> !irq);

    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != 2'b00));
endmodule

bind tcap_dual tcap_dual_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pulse_mode (pulse_mode),
    .int_mask_n (int_mask_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .hit        (hit_vec),
    .flags      (flag_vec),
    .cap_flat   (cap_flat),
    .irq        (irq)
);

// File: tb/tcap_dual_bench.sv
`timescale 1ns/1ps
// Bench: sweeps the edge selects on both channels against a counter that
// steps once per cycle, then exercises the clear handshake, the interrupt
// gating and pulse-mode blocking.
module tcap_dual_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] cnt;
    logic [1:0] pins;
    logic       pulse_mode, mask_n, sel, wr;
    logic [1:0] addr;
    logic [7:0] wdata, rdata;
    logic       irq;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;
    logic [7:0] exp_cap [2];

    always #4 clk = ~clk;

    tcap_dual u_tcap_dual (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt), .cap_pin(pins),
        .pulse_mode(pulse_mode), .int_mask_n(mask_n), .bus_sel(sel),
        .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .irq(irq)
    );

    task automatic step();
        @(negedge clk);
        cnt = cnt + 8'd1;
    endtask

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        step();
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        step();
        sel = 1'b0;
    endtask

    task automatic wrt(input logic [1:0] a, input logic [7:0] d);
        step();
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        step();
        sel = 1'b0; wr = 1'b0;
    endtask

    // Change a pin, then wait until the capture edge has passed; stamp is the R1 prediction.
    task automatic pin_to(input int ch, input logic v, output logic [7:0] stamp);
        step();
        pins[ch] = v;
        stamp = cnt + 8'd2;
        step(); step(); step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired (R10 run did not finish)");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, st;
        rst_n = 1'b0; cnt = 8'd0; pins = 2'b00; pulse_mode = 1'b0; mask_n = 1'b1;
        sel = 1'b0; wr = 1'b0; addr = 2'd0; wdata = 8'd0;
        exp_cap[0] = 8'd0; exp_cap[1] = 8'd0;
        repeat (4) step();
        rst_n = 1'b1;

        // R10: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk("R10 register reset", d, 8'd0);
        end
        chk("R10 irq reset", {7'd0, irq}, 8'd0);

        // R1 R2 R4 R5: sweep channel, edge select and both transition directions
        for (int ch = 0; ch < 2; ch++) begin
            for (int rs = 0; rs < 2; rs++) begin
                wrt(2'd0, 8'(rs << ch));
                for (int rep = 0; rep < 3; rep++) begin
                    for (int k = 0; k < 2; k++) begin
                        logic lvl;
                        logic match;
                        lvl = (k == 0);
                        match = (lvl == rs[0]);
                        pin_to(ch, lvl, st);
                        if (match) exp_cap[ch] = st;
                        rd(2'd1, d);
                        chk(match ? "R4 flag set" : "R2 wrong edge no flag", d, match ? 8'(1 << ch) : 8'd0);
                        rd(2'(2 + ch), d);
                        chk(match ? "R1 capture value" : "R2 wrong edge keeps value", d, exp_cap[ch]);
                        if (match) begin
                            rd(2'd1, d);
                            chk("R5 flag cleared", d, 8'd0);
                        end
                    end
                end
            end
        end

        // R3: writes to the capture registers are ignored
        wrt(2'd2, 8'h5A); rd(2'd2, d); chk("R3 cap1 read-only", d, exp_cap[0]);
        wrt(2'd3, 8'hC3); rd(2'd3, d); chk("R3 cap2 read-only", d, exp_cap[1]);

        // R5: a write access completes the clear
        wrt(2'd0, 8'h03);
        pin_to(0, 1'b1, st); exp_cap[0] = st;
        rd(2'd1, d); chk("R5 flag before write clear", d, 8'h01);
        wrt(2'd2, 8'hFF);
        rd(2'd1, d); chk("R5 write access clears", d, 8'h00);
        rd(2'd2, d); chk("R3 value after write clear", d, exp_cap[0]);
        pin_to(0, 1'b0, st);

        // R6: an access without a status read leaves the flag; R5 per-channel clear
        pin_to(1, 1'b1, st); exp_cap[1] = st;
        rd(2'd3, d); chk("R6 cap2 value", d, exp_cap[1]);
        rd(2'd1, d); chk("R6 no status read keeps flag", d, 8'h02);
        pin_to(0, 1'b1, st); exp_cap[0] = st;
        rd(2'd1, d); chk("R4 both flags", d, 8'h03);
        rd(2'd3, d);
        rd(2'd1, d); chk("R5 other channel untouched", d, 8'h01);
        rd(2'd2, d); chk("R1 cap1 value", d, exp_cap[0]);
        rd(2'd1, d); chk("R5 both cleared", d, 8'h00);
        pin_to(0, 1'b0, st); pin_to(1, 1'b0, st);

        // R7: a capture between status read and access cancels the clear
        pin_to(0, 1'b1, st); exp_cap[0] = st;
        rd(2'd1, d); chk("R7 armed read", d, 8'h01);
        pin_to(0, 1'b0, st);
        pin_to(0, 1'b1, st); exp_cap[0] = st;
        rd(2'd2, d); chk("R7 newer value", d, exp_cap[0]);
        rd(2'd1, d); chk("R7 flag stays set", d, 8'h01);
        rd(2'd2, d);
        rd(2'd1, d); chk("R5 clear after R7", d, 8'h00);
        pin_to(0, 1'b0, st);

        // R8: interrupt gating and pending behaviour
        pin_to(1, 1'b1, st); exp_cap[1] = st;
        chk("R8 disabled no irq", {7'd0, irq}, 8'd0);
        wrt(2'd0, 8'h07);
        #1 chk("R8 enabled irq", {7'd0, irq}, 8'd1);
        mask_n = 1'b0;
        #1 chk("R8 masked irq", {7'd0, irq}, 8'd0);
        mask_n = 1'b1;
        #1 chk("R8 pending irq returns", {7'd0, irq}, 8'd1);
        rd(2'd1, d); rd(2'd3, d);
        #1 chk("R8 irq drops after clear", {7'd0, irq}, 8'd0);
        pin_to(1, 1'b0, st);

        // R9: pulse mode blocks channel 1 only
        pulse_mode = 1'b1;
        pin_to(0, 1'b1, st);
        rd(2'd1, d); chk("R9 ch1 no flag", d, 8'h00);
        rd(2'd2, d); chk("R9 ch1 value kept", d, exp_cap[0]);
        pin_to(1, 1'b1, st); exp_cap[1] = st;
        rd(2'd1, d); chk("R9 ch2 still flags", d, 8'h02);
        rd(2'd3, d); chk("R9 ch2 value", d, exp_cap[1]);
        pin_to(0, 1'b0, st); pin_to(1, 1'b0, st);
        pulse_mode = 1'b0;
        pin_to(0, 1'b1, st); exp_cap[0] = st;
        rd(2'd1, d); chk("R9 ch1 resumes", d, 8'h01);
        rd(2'd2, d); chk("R9 ch1 resumed value", d, exp_cap[0]);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule